// File: doc/BRIEF.md
# Parity Error Reporting Unit

This unit collects error events from a bus interface and a memory controller. It records them in a sticky status register and turns selected events into system-error and parity-error request pulses. A byte-wide register port reads and writes two registers: a command register and a status register. The command register holds the per-event reporting enables. Two master-enable inputs, taken from the device's main command register, gate the requests further.

Each status bit stays set until software writes a one to its position. The two low command bits form a pair. Bit 0 enables memory parity checking, and bit 1 reports memory parity errors as a system error. The combination "report but do not check" is not allowed. A write with that combination stores bit 1 as zero.

Top module: `perr_report_unit`

## Requirements
- R1: After a synchronous reset both registers read 00h and `serr_req` and `perr_req` are low.
- R2: Event input bit i (0 write-data parity, 1 read-data parity, 2 address parity, 5 shutdown) sets status bit i, and the bit reads back as 1 one clock later. Status bits 7:6 always read 0.
- R3: A status write clears every bit whose write-data bit is 1 and leaves every bit whose write-data bit is 0 unchanged.
- R4: An event that arrives in the same cycle as a clearing write to its status bit leaves that bit set.
- R5: A command write stores the byte as written, except as R6 states. A status write cannot set any bit. Register select 0 is command and 1 is status.
- R6: A command write with bits 1:0 = 10b stores bits 1:0 as 00b and keeps bits 7:2. The values 00b, 01b and 11b are stored unchanged.
- R7: `perr_req` pulses high for one cycle, in the cycle after a write-data or read-data parity event, when command bit 7 and `dev_parity_en` are both 1.
- R8: `serr_req` pulses high for one cycle, in the cycle after an enabled event. The enables are: command bit 5 for target abort (event bit 6), bit 4 for write-data parity, bit 3 for read-data parity, bit 6 for address parity, and bit 1 for a qualified memory or cache parity event.
- R9: `serr_req` stays low whenever `dev_parity_en` or `dev_serr_en` is 0 in the event cycle. `perr_req` stays low whenever `dev_parity_en` is 0. Status latching does not depend on the master enables.
- R10: A memory parity event (bit 3) sets status bit 3 only when command bit 0 is 1. A cache parity event (bit 4) sets status bit 4 only when command bit 2 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 command, 1 status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| evt_in | input | 7 | Single-cycle event pulses (bit map in R2, R8, R10) |
| dev_parity_en | input | 1 | Master parity-response enable |
| dev_serr_en | input | 1 | Master system-error enable |
| serr_req | output | 1 | System error request pulse |
| perr_req | output | 1 | Parity error request pulse |

## Verification
An event or a register write is sampled on one rising edge. The new register contents appear at `reg_rdata` right after that edge, and the request pulses are high for the following cycle only. The bench drives each stimulus just after a falling edge and lets one rising edge pass. At the next falling edge it compares both request outputs and both registers against its reference model, stepping the register select between the two reads. It then drives the next stimulus, so a pulse that lasted too long shows up on the next comparison.

// File: rtl/perr_pkg.sv
package perr_pkg;
  localparam int REG_W  = 8;
  localparam int N_EVT  = 7;
  localparam int N_STAT = 6;

  // event / status positions
  localparam int EV_WPAR  = 0;
  localparam int EV_RPAR  = 1;
  localparam int EV_APAR  = 2;
  localparam int EV_MEM   = 3;
  localparam int EV_L2    = 4;
  localparam int EV_SHUT  = 5;
  localparam int EV_TABT  = 6;

  // command bit positions
  localparam int C_MEM_CHK  = 0;
  localparam int C_MEM_SERR = 1;
  localparam int C_L2_CHK   = 2;
  localparam int C_RPAR_SERR = 3;
  localparam int C_WPAR_SERR = 4;
  localparam int C_TABT_SERR = 5;
  localparam int C_APAR_SERR = 6;
  localparam int C_PERR_EN  = 7;
endpackage

// File: rtl/perr_cmd_reg.sv
module perr_cmd_reg
  import perr_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cmd_q
);
  logic         bad_pair;
  logic [W-1:0] wdata_fix;

  always_comb begin
    bad_pair  = wdata[C_MEM_SERR] && !wdata[C_MEM_CHK];
    wdata_fix = wdata;
    if (bad_pair) wdata_fix[C_MEM_SERR] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)        cmd_q <= '0;
    else if (wr_en) cmd_q <= wdata_fix;
  end

  // R6
  forbidden_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wdata[1:0] == 2'b10) |=> (cmd_q[1:0] == 2'b00));

  // R5
  cmd_store_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wdata[1:0] != 2'b10) |=> (cmd_q == $past(wdata)));
endmodule

// File: rtl/perr_stat_reg.sv
module perr_stat_reg
  import perr_pkg::*;
#(
  parameter int N = N_STAT
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_en,
  input  logic [N-1:0] clr_data,
  input  logic [N-1:0] set_vec,
  output logic [N-1:0] stat_q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) stat_q[i] <= 1'b0;
      else     stat_q[i] <= set_vec[i] | (stat_q[i] & ~(clr_en & clr_data[i]));
    end

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      set_vec[i] |=> stat_q[i]);

    // R3
    w1c_chk: assert property (@(posedge clk) disable iff (rst)
      (!set_vec[i] && clr_en && clr_data[i]) |=> !stat_q[i]);

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!set_vec[i] && !(clr_en && clr_data[i])) |=> $stable(stat_q[i]));
  end
endmodule

// File: rtl/perr_gate.sv
module perr_gate
  import perr_pkg::*;
#(
  parameter int W  = REG_W,
  parameter int NE = N_EVT,
  parameter int NS = N_STAT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  cmd,
  input  logic [NE-1:0] evt,
  input  logic          par_master,
  input  logic          serr_master,
  output logic [NS-1:0] latch_vec,
  output logic          serr_req,
  output logic          perr_req
);
  logic mem_q, l2_q, serr_src, perr_src;

  always_comb begin
    mem_q = evt[EV_MEM] & cmd[C_MEM_CHK];
    l2_q  = evt[EV_L2]  & cmd[C_L2_CHK];

    latch_vec          = evt[NS-1:0];
    latch_vec[EV_MEM]  = mem_q;
    latch_vec[EV_L2]   = l2_q;

    serr_src = par_master & serr_master &
               ((evt[EV_TABT] & cmd[C_TABT_SERR]) |
                (evt[EV_WPAR] & cmd[C_WPAR_SERR]) |
                (evt[EV_RPAR] & cmd[C_RPAR_SERR]) |
                (evt[EV_APAR] & cmd[C_APAR_SERR]) |
                ((mem_q | l2_q) & cmd[C_MEM_SERR]));

    perr_src = par_master & cmd[C_PERR_EN] & (evt[EV_WPAR] | evt[EV_RPAR]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      serr_req <= 1'b0;
      perr_req <= 1'b0;
    end else begin
      serr_req <= serr_src;
      perr_req <= perr_src;
    end
  end

  // R9
  serr_master_chk: assert property (@(posedge clk) disable iff (rst)
    !(par_master && serr_master) |=> !serr_req);

  // R9
  perr_master_chk: assert property (@(posedge clk) disable iff (rst)
    !par_master |=> !perr_req);

  // R7
  perr_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !(evt[EV_WPAR] || evt[EV_RPAR]) |=> !perr_req);
endmodule

// File: rtl/perr_report_unit.sv
module perr_report_unit
  import perr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [N_EVT-1:0] evt_in,
  input  logic             dev_parity_en,
  input  logic             dev_serr_en,
  output logic             serr_req,
  output logic             perr_req
);
  localparam int PAD_W = REG_W - N_STAT;

  logic [REG_W-1:0]  cmd_q;
  logic [N_STAT-1:0] stat_q;
  logic [N_STAT-1:0] latch_vec;
  logic              cmd_wr, stat_wr;

  assign cmd_wr  = reg_wr && !reg_addr;
  assign stat_wr = reg_wr &&  reg_addr;

  perr_cmd_reg #(.W(REG_W)) u_cmd (
    .clk   (clk),
    .rst   (rst),
    .wr_en (cmd_wr),
    .wdata (reg_wdata),
    .cmd_q (cmd_q)
  );

  perr_gate #(.W(REG_W), .NE(N_EVT), .NS(N_STAT)) u_gate (
    .clk         (clk),
    .rst         (rst),
    .cmd         (cmd_q),
    .evt         (evt_in),
    .par_master  (dev_parity_en),
    .serr_master (dev_serr_en),
    .latch_vec   (latch_vec),
    .serr_req    (serr_req),
    .perr_req    (perr_req)
  );

  perr_stat_reg #(.N(N_STAT)) u_stat (
    .clk      (clk),
    .rst      (rst),
    .clr_en   (stat_wr),
    .clr_data (reg_wdata[N_STAT-1:0]),
    .set_vec  (latch_vec),
    .stat_q   (stat_q)
  );

  assign reg_rdata = reg_addr ? {{PAD_W{1'b0}}, stat_q} : cmd_q;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (cmd_q == '0 && stat_q == '0 && !serr_req && !perr_req));

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    reg_addr |-> (reg_rdata[REG_W-1:N_STAT] == '0));
endmodule

// File: tb/perr_report_unit_tb.sv
module perr_report_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       reg_wr;
  logic       reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic [6:0] evt_in;
  logic       dev_parity_en;
  logic       dev_serr_en;
  logic       serr_req;
  logic       perr_req;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [7:0] cmd_m;
  logic [5:0] stat_m;
  logic       serr_m, perr_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  perr_report_unit u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in),
    .dev_parity_en(dev_parity_en), .dev_serr_en(dev_serr_en),
    .serr_req(serr_req), .perr_req(perr_req)
  );

  function automatic logic [5:0] f_latch(logic [7:0] c, logic [6:0] e);
    return {e[5], e[4] & c[2], e[3] & c[0], e[2], e[1], e[0]};
  endfunction

  function automatic logic f_serr(logic [7:0] c, logic [6:0] e, logic mp, logic ms);
    logic memq;
    memq = (e[3] & c[0]) | (e[4] & c[2]);
    return mp & ms & ((e[6] & c[5]) | (e[0] & c[4]) | (e[1] & c[3]) |
                      (e[2] & c[6]) | (memq & c[1]));
  endfunction

  function automatic logic f_perr(logic [7:0] c, logic [6:0] e, logic mp);
    return c[7] & mp & (e[0] | e[1]);
  endfunction

  function automatic logic [7:0] f_cmd(logic [7:0] w);
    return (w[1:0] == 2'b10) ? {w[7:2], 2'b00} : w;
  endfunction

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, "serr_req", {7'd0, serr_req}, {7'd0, serr_m});
    chk(req, "perr_req", {7'd0, perr_req}, {7'd0, perr_m});
    reg_addr = 1'b0; #1;
    chk(req, "command", reg_rdata, cmd_m);
    reg_addr = 1'b1; #1;
    chk(req, "status", reg_rdata, {2'b00, stat_m});
  endtask

  // called just after a falling edge
  task automatic step(string req, logic wr, logic addr, logic [7:0] wd,
                      logic [6:0] ev, logic mp, logic ms);
    reg_wr = wr; reg_addr = addr; reg_wdata = wd;
    evt_in = ev; dev_parity_en = mp; dev_serr_en = ms;
    @(posedge clk);
    serr_m = f_serr(cmd_m, ev, mp, ms);
    perr_m = f_perr(cmd_m, ev, mp);
    stat_m = f_latch(cmd_m, ev) | (stat_m & ~((wr && addr) ? wd[5:0] : 6'h00));
    if (wr && !addr) cmd_m = f_cmd(wd);
    @(negedge clk);
    reg_wr = 1'b0; evt_in = '0;
    check_all(req);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4242);
    rst = 1'b1; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    evt_in = 0; dev_parity_en = 0; dev_serr_en = 0;
    cmd_m = 0; stat_m = 0; serr_m = 0; perr_m = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check_all("R1");

    step("R5", 1, 0, 8'h85, 7'h00, 0, 0);
    step("R6", 1, 0, 8'hFA, 7'h00, 0, 0);
    step("R6", 1, 0, 8'hFB, 7'h00, 0, 0);
    step("R5", 1, 1, 8'hFF, 7'h00, 0, 0);
    step("R2", 0, 0, 8'h00, 7'h3F, 0, 0);
    step("R3", 1, 1, 8'h05, 7'h00, 0, 0);
    step("R4", 1, 1, 8'h3A, 7'h02, 0, 0);
    step("R10", 1, 0, 8'h00, 7'h00, 0, 0);
    step("R10", 0, 0, 8'h00, 7'h18, 1, 1);
    step("R10", 1, 0, 8'h01, 7'h00, 0, 0);
    step("R10", 0, 0, 8'h00, 7'h10, 1, 1);
    step("R10", 0, 0, 8'h00, 7'h08, 1, 1);
    step("R7", 1, 0, 8'h80, 7'h00, 0, 0);
    step("R7", 0, 0, 8'h00, 7'h01, 1, 0);
    step("R7", 0, 0, 8'h00, 7'h00, 1, 0);
    step("R9", 0, 0, 8'h00, 7'h02, 0, 1);
    step("R8", 1, 0, 8'h20, 7'h00, 0, 0);
    step("R8", 0, 0, 8'h00, 7'h40, 1, 1);
    step("R8", 0, 0, 8'h00, 7'h00, 1, 1);
    step("R9", 0, 0, 8'h00, 7'h40, 1, 0);
    step("R9", 0, 0, 8'h00, 7'h40, 0, 1);
    step("R8", 1, 0, 8'h03, 7'h00, 0, 0);
    step("R8", 0, 0, 8'h00, 7'h08, 1, 1);

    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      logic        wr;
      r  = $urandom;
      wr = (r[3:0] == 4'd0);
      step("R8", wr, r[4], r[15:8], 7'($urandom & $urandom & $urandom),
           r[5] | r[6], r[7] | r[16]);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule